// File: doc/BRIEF.md
# Indexed Voice Register Port

This block is the host-facing path into a bank of per-voice synthesis registers and a handful of shared control registers. The host does not address each register directly. It first loads a voice number and a function code into two select registers. It then writes through a 16-bit data window, either as a full word or as a single byte aimed at the low or the high half. Function codes 0x00 to 0x0D reach a register file of 32 voices by 16 words. A second group of codes reaches the shared registers: an active-voice count, DMA control and start words, a sample-control byte, a soft-reset/control byte and a 20-bit on-board memory pointer. A byte port stores data into on-board memory at that pointer through a simple synchronous write strobe.

Every host access is one beat on a valid/ready channel. `wr_sel` picks the target and `wr_data` carries the value. A beat is taken on any rising edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low only while `rst` is high, so outside reset the block never applies back-pressure and the host may issue one write per cycle. A beat that is not taken has no effect. The word addressed by the current selects is always visible on `win_word`. The shared registers drive plain outputs for the neighbouring engines.

Top module: `idxreg_port`

## Requirements
- R1: While the function select is 0x00..0x0D, a data-window write lands in file word (voice select bits 4..0) * 16 + (function select bits 3..0). `win_word` shows the file word at that index for the current selects, combinationally.
- R2: Byte-lane codes are `wr_sel` = 2 for the low byte (bits 7..0 replaced from data bits 7..0, bits 15..8 kept), 3 for the high byte (bits 15..8 taken from data bits 7..0, bits 7..0 kept) and 4 for the full word (all 16 bits replaced).
- R3: While bit 0 of `reset_ctrl` is 0, data-window writes to function codes 0x00..0x0D leave the voice file unchanged.
- R4: A data write with function 0x0E loads `voice_count` from data bits 7..0. Hardware reset and a soft reset (R9) set it to 0xCD.
- R5: Function 0x43 writes bits 15..0 of `mem_addr` under the byte-lane rules of R2. Function 0x44 writes bits 19..16 from data bits 3..0.
- R6: A write with `wr_sel` = 5 raises `mem_we` for exactly the next cycle, with `mem_wdata` set to data bits 7..0 and `mem_addr` set to the pointer in force.
- R7: Function 0x41 loads `dma_ctrl` from data bits 7..0. When data bit 0 is 1, `dma_req` is high for the one cycle after the write.
- R8: Function 0x42 updates `dma_start` under the byte-lane rules and clears bits 7..4 of `dma_high`. Function 0x50 loads `dma_high` from data bits 7..0.
- R9: A write to function 0x4C with data bit 0 set to 1 stores the data byte in `reset_ctrl`. With data bit 0 at 0, it stores the byte with bits 2 and 1 cleared, and it zeroes `dma_ctrl` and `samp_ctrl`.
- R10: Data writes with function 0x0F, or with any code not named in R1..R9 or R13, change no output and no register.
- R11: `mem_addr` changes only on writes to functions 0x43 and 0x44. Memory byte writes do not advance it.
- R12: `wr_sel` = 0 loads the voice select and 1 loads the function select. Codes 6 and 7 are taken and ignored.
- R13: Function 0x49 loads `samp_ctrl` from data bits 7..0.
- R14: Hardware reset clears the selects, the voice file and every shared register except `voice_count` (0xCD), and holds `wr_ready` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Host write beat offered |
| wr_ready | output | 1 | Block accepts a beat (low only in reset) |
| wr_sel | input | 3 | Target: 0 voice sel, 1 func sel, 2 low byte, 3 high byte, 4 word, 5 memory byte |
| wr_data | input | 16 | Write data |
| win_word | output | 16 | Voice file word at the current selects |
| voice_count | output | 8 | Active voice count |
| reset_ctrl | output | 8 | Soft-reset/control byte; bit 0 enables voice writes |
| dma_ctrl | output | 8 | DMA control byte |
| dma_req | output | 1 | One-cycle DMA request pulse |
| dma_start | output | 16 | DMA start word |
| dma_high | output | 8 | DMA high byte |
| samp_ctrl | output | 8 | Sample control byte |
| mem_we | output | 1 | Memory byte write strobe |
| mem_addr | output | 20 | On-board memory pointer |
| mem_wdata | output | 8 | Memory byte write data |

## Verification
A wrong word index or a bad lane merge shows on `win_word` at the first sample after the write edge. Because the read path is combinational, the error stays visible until the host moves either select. A stray side effect in the shared decode, such as a missed nibble clear, an unblocked voice write or an address that steps on a memory write, shows on the matching output one cycle after the offending beat. The bench walks the selects back to earlier words to expose writes that went to the wrong word.

// File: rtl/idxreg_pkg.sv
package idxreg_pkg;

  localparam int DATA_W = 16;

  typedef enum logic [2:0] {
    SEL_VOICE = 3'd0,
    SEL_FUNC  = 3'd1,
    SEL_DLO   = 3'd2,
    SEL_DHI   = 3'd3,
    SEL_DWORD = 3'd4,
    SEL_MEMB  = 3'd5
  } port_sel_e;

  localparam logic [7:0] FN_VOICE_LAST = 8'h0D;
  localparam logic [7:0] FN_VCOUNT     = 8'h0E;
  localparam logic [7:0] FN_DMA_CTRL   = 8'h41;
  localparam logic [7:0] FN_DMA_START  = 8'h42;
  localparam logic [7:0] FN_ADDR_LO    = 8'h43;
  localparam logic [7:0] FN_ADDR_HI    = 8'h44;
  localparam logic [7:0] FN_SAMP       = 8'h49;
  localparam logic [7:0] FN_RESET      = 8'h4C;
  localparam logic [7:0] FN_DMA_HIGH   = 8'h50;

  localparam logic [7:0] VCOUNT_INIT   = 8'hCD;
  localparam logic [7:0] RESET_KEEP    = 8'hF9;

  // Merge a write into an existing word according to its byte lane.
  function automatic logic [DATA_W-1:0] lane_merge(
    input logic [DATA_W-1:0] old_w,
    input logic [DATA_W-1:0] din,
    input logic [2:0]        sel
  );
    logic [DATA_W-1:0] res;
    case (sel)
      SEL_DLO: res = {old_w[15:8], din[7:0]};
      SEL_DHI: res = {din[7:0], old_w[7:0]};
      default: res = din;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/idxreg_decode.sv
module idxreg_decode
  import idxreg_pkg::*;
#(
  parameter int VOICE_W = 5,
  parameter int FUNC_W  = 4
) (
  input  logic                      wr_fire,
  input  logic [2:0]                wr_sel,
  input  logic [VOICE_W-1:0]        vsel_q,
  input  logic [7:0]                fsel_q,
  input  logic                      voice_enable,
  output logic                      data_wr,
  output logic                      voice_we,
  output logic [VOICE_W+FUNC_W-1:0] voice_addr,
  output logic                      glob_wr,
  output logic                      mem_wr
);

  logic is_voice_fn;

  always_comb begin
    data_wr     = wr_fire && (wr_sel == SEL_DLO || wr_sel == SEL_DHI ||
                              wr_sel == SEL_DWORD);
    is_voice_fn = (fsel_q <= FN_VOICE_LAST);
    voice_we    = data_wr && is_voice_fn && voice_enable;
    glob_wr     = data_wr && !is_voice_fn;
    mem_wr      = wr_fire && (wr_sel == SEL_MEMB);
    voice_addr  = {vsel_q, fsel_q[FUNC_W-1:0]};
  end

endmodule

// File: rtl/idxreg_voice_file.sv
module idxreg_voice_file
  import idxreg_pkg::*;
#(
  parameter int NUM_VOICES = 32,
  parameter int NUM_WORDS  = 16,
  localparam int DEPTH     = NUM_VOICES * NUM_WORDS,
  localparam int AW        = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [2:0]        wsel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] rd_arr [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        word_q <= '0;
      end else if (we && waddr == AW'(g)) begin
        word_q <= lane_merge(word_q, wdata, wsel);
      end
    end
    assign rd_arr[g] = word_q;
  end

  assign rdata = rd_arr[raddr];

endmodule

// File: rtl/idxreg_globals.sv
module idxreg_globals
  import idxreg_pkg::*;
#(
  parameter int MEM_AW = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [7:0]        fsel,
  input  logic [2:0]        wsel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              mem_wr,
  output logic [7:0]        vcount,
  output logic [7:0]        rctrl,
  output logic [7:0]        dctrl,
  output logic              dreq,
  output logic [15:0]       dstart,
  output logic [7:0]        dhigh,
  output logic [7:0]        sctrl,
  output logic [MEM_AW-1:0] maddr,
  output logic              mwe,
  output logic [7:0]        mwdata
);

  localparam int HI_W = MEM_AW - 16;

  always_ff @(posedge clk) begin
    if (rst) begin
      vcount <= VCOUNT_INIT;
      rctrl  <= '0;
      dctrl  <= '0;
      dreq   <= 1'b0;
      dstart <= '0;
      dhigh  <= '0;
      sctrl  <= '0;
      maddr  <= '0;
      mwe    <= 1'b0;
      mwdata <= '0;
    end else begin
      dreq <= 1'b0;
      mwe  <= 1'b0;
      if (mem_wr) begin
        mwe    <= 1'b1;
        mwdata <= wdata[7:0];
      end
      if (wr) begin
        case (fsel)
          FN_VCOUNT: vcount <= wdata[7:0];
          FN_DMA_CTRL: begin
            dctrl <= wdata[7:0];
            dreq  <= wdata[0];
          end
          FN_DMA_START: begin
            dstart <= lane_merge(dstart, wdata, wsel);
            dhigh  <= {4'h0, dhigh[3:0]};
          end
          FN_ADDR_LO: maddr[15:0] <= lane_merge(maddr[15:0], wdata, wsel);
          FN_ADDR_HI: maddr[MEM_AW-1:16] <= wdata[HI_W-1:0];
          FN_SAMP:     sctrl <= wdata[7:0];
          FN_DMA_HIGH: dhigh <= wdata[7:0];
          FN_RESET: begin
            if (wdata[0]) begin
              rctrl <= wdata[7:0];
            end else begin
              rctrl  <= wdata[7:0] & RESET_KEEP;
              vcount <= VCOUNT_INIT;
              dctrl  <= '0;
              sctrl  <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/idxreg_port.sv
module idxreg_port
  import idxreg_pkg::*;
#(
  parameter int NUM_VOICES = 32,
  parameter int NUM_WORDS  = 16,
  parameter int MEM_AW     = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [2:0]        wr_sel,
  input  logic [15:0]       wr_data,
  output logic [15:0]       win_word,
  output logic [7:0]        voice_count,
  output logic [7:0]        reset_ctrl,
  output logic [7:0]        dma_ctrl,
  output logic              dma_req,
  output logic [15:0]       dma_start,
  output logic [7:0]        dma_high,
  output logic [7:0]        samp_ctrl,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [7:0]        mem_wdata
);

  localparam int VOICE_W = $clog2(NUM_VOICES);
  localparam int FUNC_W  = $clog2(NUM_WORDS);
  localparam int FILE_AW = VOICE_W + FUNC_W;

  logic               wr_fire;
  logic [VOICE_W-1:0] vsel_q;
  logic [7:0]         fsel_q;
  logic               data_wr;
  logic               voice_we;
  logic [FILE_AW-1:0] voice_addr;
  logic               glob_wr;
  logic               mem_wr;

  assign wr_ready = !rst;
  assign wr_fire  = wr_valid && wr_ready;

  // Select registers
  always_ff @(posedge clk) begin
    if (rst) begin
      vsel_q <= '0;
      fsel_q <= '0;
    end else if (wr_fire) begin
      if (wr_sel == SEL_VOICE) vsel_q <= wr_data[VOICE_W-1:0];
      if (wr_sel == SEL_FUNC)  fsel_q <= wr_data[7:0];
    end
  end

  idxreg_decode #(
    .VOICE_W(VOICE_W),
    .FUNC_W (FUNC_W)
  ) u_dec (
    .wr_fire     (wr_fire),
    .wr_sel      (wr_sel),
    .vsel_q      (vsel_q),
    .fsel_q      (fsel_q),
    .voice_enable(reset_ctrl[0]),
    .data_wr     (data_wr),
    .voice_we    (voice_we),
    .voice_addr  (voice_addr),
    .glob_wr     (glob_wr),
    .mem_wr      (mem_wr)
  );

  idxreg_voice_file #(
    .NUM_VOICES(NUM_VOICES),
    .NUM_WORDS (NUM_WORDS)
  ) u_file (
    .clk  (clk),
    .rst  (rst),
    .we   (voice_we),
    .waddr(voice_addr),
    .wsel (wr_sel),
    .wdata(wr_data),
    .raddr(voice_addr),
    .rdata(win_word)
  );

  idxreg_globals #(
    .MEM_AW(MEM_AW)
  ) u_glob (
    .clk   (clk),
    .rst   (rst),
    .wr    (glob_wr),
    .fsel  (fsel_q),
    .wsel  (wr_sel),
    .wdata (wr_data),
    .mem_wr(mem_wr),
    .vcount(voice_count),
    .rctrl (reset_ctrl),
    .dctrl (dma_ctrl),
    .dreq  (dma_req),
    .dstart(dma_start),
    .dhigh (dma_high),
    .sctrl (samp_ctrl),
    .maddr (mem_addr),
    .mwe   (mem_we),
    .mwdata(mem_wdata)
  );

endmodule

// File: rtl/idxreg_port_chk.sv
module idxreg_port_chk
  import idxreg_pkg::*;
#(
  parameter int MEM_AW = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [2:0]        wr_sel,
  input logic [15:0]       wr_data,
  input logic [7:0]        fsel_q,
  input logic [15:0]       win_word,
  input logic [7:0]        voice_count,
  input logic [7:0]        reset_ctrl,
  input logic [7:0]        dma_ctrl,
  input logic              dma_req,
  input logic [7:0]        samp_ctrl,
  input logic              mem_we,
  input logic [MEM_AW-1:0] mem_addr,
  input logic [7:0]        mem_wdata
);

  logic fire, dwr;
  assign fire = wr_valid && wr_ready;
  assign dwr  = fire && (wr_sel == SEL_DLO || wr_sel == SEL_DHI || wr_sel == SEL_DWORD);

  assert_ready_low_R14: assert property (@(posedge clk) rst |-> !wr_ready);

  assert_mem_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ($past(fire && wr_sel == SEL_MEMB) && mem_wdata == $past(wr_data[7:0])));

  assert_dma_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> $past(dwr && fsel_q == FN_DMA_CTRL && wr_data[0]));

  assert_addr_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !(dwr && (fsel_q == FN_ADDR_LO || fsel_q == FN_ADDR_HI)) |=> $stable(mem_addr));

  assert_soft_reset_R9: assert property (@(posedge clk) disable iff (rst)
    (dwr && fsel_q == FN_RESET && !wr_data[0]) |=>
      (voice_count == VCOUNT_INIT && dma_ctrl == 8'h00 && samp_ctrl == 8'h00 &&
       (reset_ctrl & 8'h06) == 8'h00));

  assert_voice_blocked_R3: assert property (@(posedge clk) disable iff (rst)
    (dwr && fsel_q <= FN_VOICE_LAST && !reset_ctrl[0]) |=> $stable(win_word));

endmodule

bind idxreg_port idxreg_port_chk #(.MEM_AW(MEM_AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .wr_sel     (wr_sel),
  .wr_data    (wr_data),
  .fsel_q     (fsel_q),
  .win_word   (win_word),
  .voice_count(voice_count),
  .reset_ctrl (reset_ctrl),
  .dma_ctrl   (dma_ctrl),
  .dma_req    (dma_req),
  .samp_ctrl  (samp_ctrl),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata)
);

// File: tb/tb_idxreg_port.sv
`timescale 1ns/1ps
module tb_idxreg_port;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_valid;
  logic        wr_ready;
  logic [2:0]  wr_sel;
  logic [15:0] wr_data;
  logic [15:0] win_word;
  logic [7:0]  voice_count, reset_ctrl, dma_ctrl, dma_high, samp_ctrl, mem_wdata;
  logic        dma_req, mem_we;
  logic [15:0] dma_start;
  logic [19:0] mem_addr;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  idxreg_port dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_sel(wr_sel), .wr_data(wr_data), .win_word(win_word),
    .voice_count(voice_count), .reset_ctrl(reset_ctrl), .dma_ctrl(dma_ctrl),
    .dma_req(dma_req), .dma_start(dma_start), .dma_high(dma_high),
    .samp_ctrl(samp_ctrl), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata)
  );

  // {sel[3], data[16], observe[4], expected[20]}
  // observe: 0 none, 1 win_word, 2 voice_count, 3 mem_addr, 4 dma_start,
  //          5 dma_high, 6 reset_ctrl, 7 samp_ctrl, 8 dma_ctrl
  localparam int NV = 34;
  localparam logic [42:0] VEC [NV] = '{
    {3'd1, 16'h004C, 4'd0, 20'h00000},
    {3'd2, 16'h0001, 4'd6, 20'h00001}, // R9 enable voices
    {3'd0, 16'h0003, 4'd0, 20'h00000},
    {3'd1, 16'h0005, 4'd0, 20'h00000},
    {3'd4, 16'hABCD, 4'd1, 20'h0ABCD}, // R1
    {3'd2, 16'h0012, 4'd1, 20'h0AB12}, // R2 low lane
    {3'd3, 16'h0034, 4'd1, 20'h03412}, // R2 high lane
    {3'd0, 16'h001F, 4'd1, 20'h00000}, // R1 other voice
    {3'd4, 16'h1111, 4'd1, 20'h01111},
    {3'd0, 16'h0023, 4'd1, 20'h03412}, // R1 voice low 5 bits
    {3'd1, 16'h000D, 4'd1, 20'h00000},
    {3'd4, 16'h0D0D, 4'd1, 20'h00D0D}, // R1 last voice code
    {3'd1, 16'h000E, 4'd0, 20'h00000},
    {3'd2, 16'h0010, 4'd2, 20'h00010}, // R4
    {3'd1, 16'h0043, 4'd0, 20'h00000},
    {3'd4, 16'h5678, 4'd3, 20'h05678}, // R5
    {3'd3, 16'h009A, 4'd3, 20'h09A78}, // R5 high lane
    {3'd1, 16'h0044, 4'd0, 20'h00000},
    {3'd2, 16'h00F3, 4'd3, 20'h39A78}, // R5 top nibble
    {3'd1, 16'h0042, 4'd0, 20'h00000},
    {3'd4, 16'h2222, 4'd4, 20'h02222}, // R8
    {3'd1, 16'h0050, 4'd0, 20'h00000},
    {3'd2, 16'h00FF, 4'd5, 20'h000FF}, // R8 high byte load
    {3'd1, 16'h0042, 4'd0, 20'h00000},
    {3'd2, 16'h0033, 4'd4, 20'h02233}, // R8 lane merge
    {3'd6, 16'hFFFF, 4'd5, 20'h0000F}, // R8 nibble clear, R12 sel 6 ignored
    {3'd1, 16'h0049, 4'd0, 20'h00000},
    {3'd2, 16'h005A, 4'd7, 20'h0005A}, // R13
    {3'd1, 16'h0041, 4'd0, 20'h00000},
    {3'd2, 16'h0004, 4'd8, 20'h00004}, // R7
    {3'd1, 16'h000F, 4'd0, 20'h00000},
    {3'd4, 16'hFFFF, 4'd2, 20'h00010}, // R10 code 0x0F
    {3'd1, 16'h0060, 4'd0, 20'h00000},
    {3'd4, 16'hFFFF, 4'd7, 20'h0005A}  // R10 undefined code
  };

  function automatic logic [19:0] observe(input logic [3:0] k);
    case (k)
      4'd1: return {4'h0, win_word};
      4'd2: return {12'h0, voice_count};
      4'd3: return mem_addr;
      4'd4: return {4'h0, dma_start};
      4'd5: return {12'h0, dma_high};
      4'd6: return {12'h0, reset_ctrl};
      4'd7: return {12'h0, samp_ctrl};
      4'd8: return {12'h0, dma_ctrl};
      default: return 20'h0;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] k);
    case (k)
      4'd1: return "R1/R2";
      4'd2: return "R4/R10";
      4'd3: return "R5";
      4'd4: return "R8";
      4'd5: return "R8/R12";
      4'd6: return "R9";
      4'd7: return "R13/R10";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Issue one beat; returns at the negedge after the accepting edge.
  task automatic put(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_sel   = s;
    wr_data  = d;
    @(posedge clk);
    #1;
    wr_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_valid = 1'b0; wr_sel = 3'd0; wr_data = 16'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R14 ready in reset", {19'h0, wr_ready}, 20'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R14 ready after reset", {19'h0, wr_ready}, 20'h1);
    check("R14 count init", {12'h0, voice_count}, 20'h000CD);
    check("R14 ctrl init", {12'h0, reset_ctrl}, 20'h0);
    check("R14 addr init", mem_addr, 20'h0);
    check("R14 window init", {4'h0, win_word}, 20'h0);

    for (int i = 0; i < NV; i++) begin
      put(VEC[i][42:40], VEC[i][39:24]);
      if (VEC[i][23:20] != 4'd0)
        check(req_of(VEC[i][23:20]), observe(VEC[i][23:20]), VEC[i][19:0]);
    end

    // R6 memory byte strobe, R11 pointer does not step
    put(3'd5, 16'h00C3);
    check("R6 mem_we", {19'h0, mem_we}, 20'h1);
    check("R6 mem_wdata", {12'h0, mem_wdata}, 20'h000C3);
    check("R6 mem_addr", mem_addr, 20'h39A78);
    @(negedge clk);
    check("R6 strobe one cycle", {19'h0, mem_we}, 20'h0);
    check("R11 no increment", mem_addr, 20'h39A78);

    // R7 DMA request pulse
    put(3'd1, 16'h0041);
    put(3'd2, 16'h0005);
    check("R7 dma_req", {19'h0, dma_req}, 20'h1);
    @(negedge clk);
    check("R7 dma_req one cycle", {19'h0, dma_req}, 20'h0);

    // R9 soft reset
    put(3'd1, 16'h004C);
    put(3'd2, 16'h0006);
    check("R9 ctrl bits cleared", {12'h0, reset_ctrl}, 20'h0);
    check("R4 count back to CD", {12'h0, voice_count}, 20'h000CD);
    check("R9 samp cleared", {12'h0, samp_ctrl}, 20'h0);
    check("R9 dma ctrl cleared", {12'h0, dma_ctrl}, 20'h0);

    // R3 voice writes blocked
    put(3'd0, 16'h0003);
    put(3'd1, 16'h0005);
    put(3'd4, 16'h7777);
    check("R3 blocked word", {4'h0, win_word}, 20'h03412);

    // R14 hardware reset
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R14 ready low", {19'h0, wr_ready}, 20'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R14 count after reset", {12'h0, voice_count}, 20'h000CD);
    check("R14 addr after reset", mem_addr, 20'h0);
    check("R14 dma_high after reset", {12'h0, dma_high}, 20'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule